// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block holds the configuration state of an interrupt router and exposes it through a small memory-mapped port. Software first writes an 8-bit selector and then reads or writes a 32-bit data window. Depending on the selector, the window reaches an identification register, a read-only version word, or one half of a 64-bit routing entry. There is one routing entry per interrupt pin. A third offset takes end-of-interrupt vector numbers.

A neighbouring service block consumes the decoded per-pin fields: mask, trigger mode and vector. That block also reports when a level-triggered pin has been accepted, which sets the entry's remote-pending bit. Its companion output is a one-cycle clear pulse per pin. The pulse fires whenever that pending bit is cleared, either by a low-half rewrite or by a matching end-of-interrupt. The end-of-interrupt vector itself is also forwarded as a one-cycle event.

Top module: `irq_regwin`

## Requirements
- R1: Bus offset 0x00 holds the 8-bit selector. A write keeps bus_wdata[7:0]. A read returns the selector in bits 7:0 with the upper bits zero. Reset sets it to 0.
- R2: The window at offset 0x10 with selector 0x01 reads (pins-1) in bits 23:16 and the version code 0x11 in bits 7:0. With 24 pins this is 0x00170011. Writes there change nothing.
- R3: Selector 0x00 writes bus_wdata[27:24] into a 4-bit ID. Selectors 0x00 and 0x02 both read the ID in bits 27:24 and zero elsewhere. A window write under selector 0x02 is ignored.
- R4: A selector of 0x10 or above addresses entry (selector-0x10)>>1. An even selector reaches the low word and an odd selector the high word. Low-word layout: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-pending 14, trigger mode 15 (1 = level), mask 16. The high word holds the destination in bits 31:24. All other bits read zero. Writes appear on the exported fields (mask_out, trig_out, vec_out) from the next cycle.
- R5: A low-word write clears the entry's remote-pending bit, ignoring the written bit 14, and raises rirr_clr for that pin for one cycle after the write edge. A high-word write leaves remote-pending unchanged.
- R6: Entry indices at or beyond the pin count (selector 0x40 and up) drop writes with no effect. Reads of them return zero, and so do reads of the unused selectors 0x03 to 0x0F.
- R7: A write at offset 0x40 raises eoi_valid for one cycle after the write edge, with eoi_vector equal to bus_wdata[7:0]. Every level-triggered entry whose vector matches has its remote-pending bit cleared and its rirr_clr pulsed. Edge-triggered and non-matching entries are untouched.
- R8: Reset sets every mask bit and clears every other entry field and the ID.
- R9: rirr_set[i] sets entry i's remote-pending bit only while the entry is level-triggered. A clear event in the same cycle takes priority over the set.
- R10: Writes to any other offset, including offsets that are not 16-byte aligned, have no effect. Reads of those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for bus_addr (combinational) |
| rirr_set | input | NUM_PINS | Per-pin accept report from the service block |
| mask_out | output | NUM_PINS | Per-pin mask field |
| trig_out | output | NUM_PINS | Per-pin trigger mode (1 = level) |
| rirr_out | output | NUM_PINS | Per-pin remote-pending bit |
| vec_out | output | 8*NUM_PINS | Per-pin vector, pin i in bits 8i+7:8i |
| rirr_clr | output | NUM_PINS | One-cycle pulse when a pin's remote-pending is cleared |
| eoi_valid | output | 1 | One-cycle end-of-interrupt event |
| eoi_vector | output | 8 | Vector carried by the event |

## Verification
The assertions assume that a bus write lasts exactly one cycle with bus_we high. They also assume that rirr_set is a per-pin level sampled at each edge, with no relation required to the bus. The stimulus therefore drives every input on the falling edge and holds bus_we for a single cycle per write. It reads only through the combinational rd_data after settling. It overlaps rirr_set with a clearing write only in the one directed case that checks clear-over-set priority.

// File: rtl/irw_pkg.sv
package irw_pkg;

    localparam logic [7:0] OFF_SEL  = 8'h00;
    localparam logic [7:0] OFF_WIN  = 8'h10;
    localparam logic [7:0] OFF_EOI  = 8'h40;
    localparam logic [7:0] SEL_ID   = 8'h00;
    localparam logic [7:0] SEL_VER  = 8'h01;
    localparam logic [7:0] SEL_ARB  = 8'h02;
    localparam logic [7:0] SEL_TBL  = 8'h10;
    localparam logic [7:0] VER_CODE = 8'h11;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       trig;
        logic       rirr;
        logic       pol;
        logic       dmode;
        logic [2:0] dlv;
        logic [7:0] vec;
    } entry_t;

    localparam entry_t ENTRY_RST = '{dest: 8'h00, mask: 1'b1, trig: 1'b0,
                                     rirr: 1'b0, pol: 1'b0, dmode: 1'b0,
                                     dlv: 3'h0, vec: 8'h00};

    typedef enum logic [2:0] {
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_TBL,
        TGT_NONE
    } target_e;

    typedef struct packed {
        logic sel_we;
        logic win_we;
        logic eoi_we;
        logic sel_rd;
        logic win_rd;
    } strobe_t;

    function automatic logic [31:0] pack_lo(entry_t e);
        return {15'h0, e.mask, e.trig, e.rirr, e.pol, 1'b0, e.dmode, e.dlv, e.vec};
    endfunction

    function automatic logic [31:0] pack_hi(entry_t e);
        return {e.dest, 24'h0};
    endfunction

endpackage

// File: rtl/irw_decode.sv
module irw_decode
    import irw_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic [7:0]       bus_addr,
    input  logic             bus_we,
    input  logic [7:0]       sel_q,
    output strobe_t          strb,
    output target_e          target,
    output logic [IDX_W-1:0] tbl_idx,
    output logic             tbl_hi
);
    logic [7:0] raw_idx;

    always_comb begin
        raw_idx = 8'(sel_q - SEL_TBL) >> 1;
        tbl_idx = raw_idx[IDX_W-1:0];
        tbl_hi  = sel_q[0];

        if (sel_q == SEL_ID)
            target = TGT_ID;
        else if (sel_q == SEL_VER)
            target = TGT_VER;
        else if (sel_q == SEL_ARB)
            target = TGT_ARB;
        else if (sel_q >= SEL_TBL && raw_idx < 8'(NUM_PINS))
            target = TGT_TBL;
        else
            target = TGT_NONE;

        strb.sel_rd = (bus_addr == OFF_SEL);
        strb.win_rd = (bus_addr == OFF_WIN);
        strb.sel_we = bus_we && (bus_addr == OFF_SEL);
        strb.win_we = bus_we && (bus_addr == OFF_WIN);
        strb.eoi_we = bus_we && (bus_addr == OFF_EOI);
    end
endmodule

// File: rtl/irw_entry.sv
module irw_entry
    import irw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    input  logic        eoi_we,
    input  logic [7:0]  eoi_vec,
    output entry_t      ent,
    output logic        rirr_clr
);
    logic eoi_hit;
    logic clr_evt;

    always_comb begin
        eoi_hit = eoi_we && ent.trig && (ent.vec == eoi_vec);
        clr_evt = wr_lo || eoi_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent      <= ENTRY_RST;
            rirr_clr <= 1'b0;
        end else begin
            rirr_clr <= clr_evt;
            if (wr_lo) begin
                ent.vec   <= wdata[7:0];
                ent.dlv   <= wdata[10:8];
                ent.dmode <= wdata[11];
                ent.pol   <= wdata[13];
                ent.trig  <= wdata[15];
                ent.mask  <= wdata[16];
            end
            if (wr_hi)
                ent.dest <= wdata[31:24];
            if (clr_evt)
                ent.rirr <= 1'b0;
            else if (rirr_set && ent.trig)
                ent.rirr <= 1'b1;
        end
    end
endmodule

// File: rtl/irw_rdmux.sv
module irw_rdmux
    import irw_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  strobe_t                     strb,
    input  target_e                     target,
    input  logic [IDX_W-1:0]            tbl_idx,
    input  logic                        tbl_hi,
    input  logic [7:0]                  sel_q,
    input  logic [3:0]                  id_q,
    input  entry_t [NUM_PINS-1:0]       ents,
    output logic [31:0]                 rd_data
);
    localparam logic [7:0] LAST_PIN = 8'(NUM_PINS - 1);

    logic [31:0] win_data;
    entry_t      pick;

    always_comb begin
        pick = ENTRY_RST;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (tbl_idx == IDX_W'(i))
                pick = ents[i];
        end

        unique case (target)
            TGT_ID, TGT_ARB: win_data = {4'h0, id_q, 24'h0};
            TGT_VER:         win_data = {8'h0, LAST_PIN, 8'h0, VER_CODE};
            TGT_TBL:         win_data = tbl_hi ? pack_hi(pick) : pack_lo(pick);
            default:         win_data = 32'h0;
        endcase

        if (strb.sel_rd)
            rd_data = {24'h0, sel_q};
        else if (strb.win_rd)
            rd_data = win_data;
        else
            rd_data = 32'h0;
    end
endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
    import irw_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [7:0]            bus_addr,
    input  logic                  bus_we,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           rd_data,
    input  logic [NUM_PINS-1:0]   rirr_set,
    output logic [NUM_PINS-1:0]   mask_out,
    output logic [NUM_PINS-1:0]   trig_out,
    output logic [NUM_PINS-1:0]   rirr_out,
    output logic [8*NUM_PINS-1:0] vec_out,
    output logic [NUM_PINS-1:0]   rirr_clr,
    output logic                  eoi_valid,
    output logic [7:0]            eoi_vector
);
    strobe_t               strb;
    target_e               target;
    logic [IDX_W-1:0]      tbl_idx;
    logic                  tbl_hi;
    logic [7:0]            sel_q;
    logic [3:0]            id_q;
    entry_t [NUM_PINS-1:0] ents;

    irw_decode #(.NUM_PINS(NUM_PINS)) u_dec (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .sel_q    (sel_q),
        .strb     (strb),
        .target   (target),
        .tbl_idx  (tbl_idx),
        .tbl_hi   (tbl_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q      <= 8'h00;
            id_q       <= 4'h0;
            eoi_valid  <= 1'b0;
            eoi_vector <= 8'h00;
        end else begin
            eoi_valid <= strb.eoi_we;
            if (strb.sel_we)
                sel_q <= bus_wdata[7:0];
            if (strb.win_we && target == TGT_ID)
                id_q <= bus_wdata[27:24];
            if (strb.eoi_we)
                eoi_vector <= bus_wdata[7:0];
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic wr_lo;
        logic wr_hi;
        assign wr_lo = strb.win_we && target == TGT_TBL && tbl_idx == IDX_W'(i) && !tbl_hi;
        assign wr_hi = strb.win_we && target == TGT_TBL && tbl_idx == IDX_W'(i) && tbl_hi;

        irw_entry u_ent (
            .clk      (clk),
            .rst      (rst),
            .wr_lo    (wr_lo),
            .wr_hi    (wr_hi),
            .wdata    (bus_wdata),
            .rirr_set (rirr_set[i]),
            .eoi_we   (strb.eoi_we),
            .eoi_vec  (bus_wdata[7:0]),
            .ent      (ents[i]),
            .rirr_clr (rirr_clr[i])
        );

        assign mask_out[i]       = ents[i].mask;
        assign trig_out[i]       = ents[i].trig;
        assign rirr_out[i]       = ents[i].rirr;
        assign vec_out[8*i +: 8] = ents[i].vec;
    end

    irw_rdmux #(.NUM_PINS(NUM_PINS)) u_rd (
        .strb    (strb),
        .target  (target),
        .tbl_idx (tbl_idx),
        .tbl_hi  (tbl_hi),
        .sel_q   (sel_q),
        .id_q    (id_q),
        .ents    (ents),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/irw_checker.sv
module irw_checker
    import irw_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input logic                clk,
    input logic                rst,
    input logic [7:0]          bus_addr,
    input logic                bus_we,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         rd_data,
    input logic [7:0]          sel_q,
    input logic [NUM_PINS-1:0] rirr_set,
    input logic [NUM_PINS-1:0] mask_out,
    input logic [NUM_PINS-1:0] trig_out,
    input logic [NUM_PINS-1:0] rirr_out,
    input logic [NUM_PINS-1:0] rirr_clr,
    input logic                eoi_valid,
    input logic [7:0]          eoi_vector
);
    localparam logic [31:0] VER_WORD = {8'h0, 8'(NUM_PINS - 1), 8'h0, VER_CODE};

    assert_ver_word_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_WIN && sel_q == SEL_VER) |-> rd_data == VER_WORD);

    assert_sel_read_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_SEL) |-> rd_data == {24'h0, sel_q});

    assert_eoi_from_write_R7: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |-> $past(bus_we && bus_addr == OFF_EOI));

    assert_eoi_vector_R7: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |-> eoi_vector == $past(bus_wdata[7:0]));

    assert_clear_pulsed_R5: assert property (@(posedge clk) disable iff (rst)
        (($past(rirr_out) & ~rirr_out) & ~rirr_clr) == '0);

    assert_set_needs_level_R9: assert property (@(posedge clk) disable iff (rst)
        ((rirr_out & ~$past(rirr_out)) & ~$past(rirr_set & trig_out)) == '0);

    assert_mask_by_write_R4: assert property (@(posedge clk) disable iff (rst)
        (mask_out != $past(mask_out)) |-> $past(bus_we && bus_addr == OFF_WIN));

    assert_other_offsets_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != OFF_SEL && bus_addr != OFF_WIN) |-> rd_data == 32'h0);
endmodule

bind irq_regwin irw_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .rd_data    (rd_data),
    .sel_q      (sel_q),
    .rirr_set   (rirr_set),
    .mask_out   (mask_out),
    .trig_out   (trig_out),
    .rirr_out   (rirr_out),
    .rirr_clr   (rirr_clr),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector)
);

// File: tb/irq_regwin_tb.sv
module irq_regwin_tb;
    localparam int N = 24;

    logic          clk = 1'b0;
    logic          rst;
    logic [7:0]    bus_addr;
    logic          bus_we;
    logic [31:0]   bus_wdata;
    logic [31:0]   rd_data;
    logic [N-1:0]  rirr_set;
    logic [N-1:0]  mask_out, trig_out, rirr_out, rirr_clr;
    logic [8*N-1:0] vec_out;
    logic          eoi_valid;
    logic [7:0]    eoi_vector;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    irq_regwin #(.NUM_PINS(N)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .rirr_set(rirr_set),
        .mask_out(mask_out), .trig_out(trig_out), .rirr_out(rirr_out),
        .vec_out(vec_out), .rirr_clr(rirr_clr), .eoi_valid(eoi_valid),
        .eoi_vector(eoi_vector)
    );

    // op(1: 1=read check) addr(8) data(32) expect(32)
    localparam int NV = 24;
    localparam logic [72:0] VEC [NV] = '{
        {1'b0, 8'h00, 32'h00000001, 32'h0},           // sel = version
        {1'b1, 8'h10, 32'h0, 32'h00170011},           // R2
        {1'b0, 8'h10, 32'hFFFFFFFF, 32'h0},           // R2 write ignored
        {1'b1, 8'h10, 32'h0, 32'h00170011},           // R2
        {1'b0, 8'h00, 32'h00000000, 32'h0},           // sel = id
        {1'b0, 8'h10, 32'hFA000000, 32'h0},           // R3 id = A
        {1'b1, 8'h10, 32'h0, 32'h0A000000},           // R3
        {1'b0, 8'h00, 32'h00000002, 32'h0},           // sel = arb
        {1'b1, 8'h10, 32'h0, 32'h0A000000},           // R3 alias
        {1'b0, 8'h10, 32'h05000000, 32'h0},           // R3 ignored
        {1'b1, 8'h10, 32'h0, 32'h0A000000},           // R3
        {1'b0, 8'h00, 32'h00000012, 32'h0},           // entry 1 low
        {1'b0, 8'h10, 32'hFFFFFFFF, 32'h0},
        {1'b1, 8'h10, 32'h0, 32'h0001AFFF},           // R4 low layout
        {1'b0, 8'h00, 32'h00000013, 32'h0},           // entry 1 high
        {1'b0, 8'h10, 32'hFFFFFFFF, 32'h0},
        {1'b1, 8'h10, 32'h0, 32'hFF000000},           // R4 high layout
        {1'b0, 8'h00, 32'h00000003, 32'h0},           // unused selector
        {1'b1, 8'h10, 32'h0, 32'h00000000},           // R6
        {1'b0, 8'h00, 32'h00000040, 32'h0},           // index 24
        {1'b0, 8'h10, 32'hFFFFFFFF, 32'h0},           // R6 dropped
        {1'b1, 8'h10, 32'h0, 32'h00000000},           // R6
        {1'b0, 8'h00, 32'hABCD01FF, 32'h0},           // R1 low byte only
        {1'b1, 8'h00, 32'h0, 32'h000000FF}            // R1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse_set(input int pin);
        @(negedge clk);
        rirr_set[pin] = 1'b1;
        @(negedge clk);
        rirr_set = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #800000;
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        rst = 1'b1; bus_addr = 8'h0; bus_we = 1'b0; bus_wdata = '0; rirr_set = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(8'h00, r);
        chk("R1 reset selector", r, 32'h0);
        chk("R8 reset masks", 32'(mask_out), 32'h00FFFFFF);
        chk("R8 reset trig", 32'(trig_out), 32'h0);
        chk("R8 reset rirr", 32'(rirr_out), 32'h0);
        chk("R7 reset eoi_valid", 32'(eoi_valid), 32'h0);
        wr(8'h00, 32'h00000000);
        rd(8'h10, r);
        chk("R8 reset id", r, 32'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) begin
                rd(VEC[i][71:64], r);
                chk($sformatf("R1-R6 vector %0d", i), r, VEC[i][31:0]);
            end else begin
                wr(VEC[i][71:64], VEC[i][63:32]);
            end
        end
        chk("R6 no side effect on masks", 32'(mask_out), 32'h00FFFFFF);

        // entry 2: level, unmasked, vector 0x33; entry 3: edge, vector 0x33
        wr(8'h00, 32'h14);
        wr(8'h10, 32'h00008033);
        wr(8'h00, 32'h16);
        wr(8'h10, 32'h00000033);
        chk("R4 export vector", 32'(vec_out[23:16]), 32'h33);
        chk("R4 export trig", 32'(trig_out[3:2]), 32'h1);
        chk("R4 export mask", 32'(mask_out[3:2]), 32'h0);

        pulse_set(2);
        pulse_set(3);
        chk("R9 level set", 32'(rirr_out[3:2]), 32'h1);
        wr(8'h00, 32'h14);
        rd(8'h10, r);
        chk("R4 remote-pending readback", r, 32'h0000C033);

        wr(8'h00, 32'h15);
        wr(8'h10, 32'h12000000);
        chk("R5 high write keeps rirr", 32'(rirr_out[2]), 32'h1);

        wr(8'h40, 32'hFFFFFF33);
        chk("R7 eoi_valid", 32'(eoi_valid), 32'h1);
        chk("R7 eoi_vector", 32'(eoi_vector), 32'h33);
        chk("R7 clear pulse level only", 32'(rirr_clr[3:2]), 32'h1);
        chk("R7 rirr cleared", 32'(rirr_out[2]), 32'h0);
        @(negedge clk);
        chk("R7 eoi one cycle", 32'(eoi_valid), 32'h0);
        chk("R7 clear pulse one cycle", 32'(rirr_clr[2]), 32'h0);

        pulse_set(2);
        wr(8'h40, 32'h34);
        chk("R7 non-matching vector", 32'(rirr_out[2]), 32'h1);
        chk("R7 non-matching no pulse", 32'(rirr_clr[2]), 32'h0);

        wr(8'h00, 32'h14);
        wr(8'h10, 32'h0000C033);
        chk("R5 low write clears", 32'(rirr_out[2]), 32'h0);
        chk("R5 low write pulse", 32'(rirr_clr[2]), 32'h1);

        // clear beats set in the same cycle
        @(negedge clk);
        rirr_set[2] = 1'b1;
        bus_addr = 8'h40; bus_wdata = 32'h33; bus_we = 1'b1;
        @(negedge clk);
        rirr_set = '0; bus_we = 1'b0;
        chk("R9 clear priority", 32'(rirr_out[2]), 32'h0);

        // unaligned and unused offsets
        wr(8'h11, 32'h0);
        wr(8'h20, 32'h0);
        rd(8'h10, r);
        chk("R10 stray writes ignored", r, 32'h00008033);
        rd(8'h04, r);
        chk("R10 stray read zero", r, 32'h0);
        rd(8'h40, r);
        chk("R10 eoi offset reads zero", r, 32'h0);

        finish_run();
    end
endmodule